// File: doc/BRIEF.md
# I/O Read/Write Bus Handback Sequencer

This block answers CPU I/O cycles on behalf of a slower responder. An external flag inserts wait states while an I/O request is pending, so the CPU stays parked. When the sequencer sees the active-low I/O request together with a read or write strobe, it latches the port index and the direction and serves the cycle from a small internal register file.

On a write, it takes the data bus into the selected entry. It then clears the wait flag with a single-cycle low pulse. On a read, it first turns on its data drivers with the selected entry. Next it raises a bus request, and only then pulses the wait-flag clear. While the drivers stay on, the CPU finishes the cycle and floats its own data lines. Once bus acknowledge arrives, the sequencer switches its drivers off. It drops the bus request only in the cycle after that. The handback therefore never puts two drivers on the data bus, and the CPU clock is never touched.

Every input is assumed to be synchronous to `clk` already. The CPU clock runs freely and stays outside this block.

Top module: `io_handback_seq`

## Requirements
- R1: While reset is held (synchronous, active low) and in the first cycle after it, `busrq_n` and `wait_clr_n` are 1, `data_oe` is 0 and `data_out` is 0. All register-file entries reset to 0.
- R2: Service starts only when `ioreq_n` is 0 and at least one of `rd_n` or `wr_n` is 0. With `ioreq_n` low and both strobes high, no output changes.
- R3: On a write (`wr_n` = 0), the value on `data_in` is stored into the entry selected by `port_sel`. `wait_clr_n` goes low two cycles after the request is seen. `busrq_n` stays 1 for the whole write service.
- R4: On a read (`rd_n` = 0), `data_oe` goes to 1 with the selected entry on `data_out` two cycles after the request is seen. `busrq_n` goes to 0 one cycle later. `wait_clr_n` pulses low one cycle after that.
- R5: After the wait-clear pulse of a read, `data_oe` stays 1 and `busrq_n` stays 0 for as long as `busack_n` is 1, with no upper limit.
- R6: After `busack_n` is seen at 0, `data_oe` goes to 0 on the next cycle while `busrq_n` is still 0. `busrq_n` returns to 1 one cycle later.
- R7: Each request gets exactly one service. After a service ends, no new one starts until `ioreq_n` has returned to 1.
- R8: `wait_clr_n` is low for exactly one cycle per service.
- R9: A write changes only the entry it selects. The other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ioreq_n | input | 1 | CPU I/O request, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| port_sel | input | IDX_W (2) | Low port-address bits selecting a register entry |
| data_in | input | DW (8) | Data bus as seen by the block |
| busack_n | input | 1 | CPU bus acknowledge, active low |
| data_out | output | DW (8) | Response byte, zero while drivers are off |
| data_oe | output | 1 | Enables the block's data-bus drivers |
| busrq_n | output | 1 | Bus request to the CPU, active low |
| wait_clr_n | output | 1 | Clear pulse to the wait-state flag, active low |

## Verification
A wrong state in the sequencer is visible at the ports within one cycle, because every output is decoded directly from the state. A skipped request phase shows up as `wait_clr_n` falling while `busrq_n` is still high. An early exit from the acknowledge wait shows up as `data_oe` dropping while `busack_n` is still 1. Reversed teardown order shows up as `busrq_n` rising in the same cycle as `data_oe` falls or earlier. A bad write index or a bad write enable appears only at the next read of the affected entry, as a wrong `data_out`.

// File: rtl/io_handback_pkg.sv
// Package: shared types for the I/O handback sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package io_handback_pkg;

    // Service sequence states, in the order a read visits them.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_CAPTURE  = 3'd1,
        ST_DRIVE    = 3'd2,
        ST_REQBUS   = 3'd3,
        ST_RELEASE  = 3'd4,
        ST_WAIT_ACK = 3'd5,
        ST_TRISTATE = 3'd6,
        ST_DONE     = 3'd7
    } hb_state_e;

endpackage

// File: rtl/io_handback_capture.sv
// Module: io_handback_capture
// Latches the port index and the transfer direction when a service starts.
// Assumes: load is a single-cycle strobe raised by the sequencer in idle.
module io_handback_capture #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] sel_in,
    input  logic             rd_n,
    output logic [IDX_W-1:0] idx_q,
    output logic             is_read_q
);

    // Hold the index and direction for the whole service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            is_read_q <= 1'b0;
        end else if (load) begin
            idx_q     <= sel_in;
            is_read_q <= ~rd_n;
        end
    end

endmodule

// File: rtl/io_handback_regfile.sv
// Module: io_handback_regfile
// Small port register file: one write port and one combinational read port.
// Assumes: a write and a read of the same entry never fall in the same cycle.
module io_handback_regfile #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [DW-1:0]    rdata
);

    logic [DW-1:0] entry_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        // Each entry loads only when its own index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q[gi] <= '0;
            else if (we && (widx == IDX_W'(gi)))
                entry_q[gi] <= wdata;
        end
    end

    // Read mux.
    always_comb begin
        rdata = entry_q[ridx];
    end

endmodule

// File: rtl/io_handback_fsm.sv
// Module: io_handback_fsm
// Steps through one I/O service and decodes all bus-facing controls from its state.
// Assumes: inputs are synchronous to clk; the wait-state flag sits outside the block.
module io_handback_fsm
    import io_handback_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ioreq_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic busack_n,
    input  logic is_read_q,
    output logic cap_load,
    output logic rf_we,
    output logic drv_en,
    output logic busrq_n,
    output logic wait_clr_n
);

    hb_state_e state_q, state_d;
    logic      start;

    assign start = ~ioreq_n & (~rd_n | ~wr_n);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_CAPTURE;
            ST_CAPTURE:  state_d = is_read_q ? ST_DRIVE : ST_RELEASE;
            ST_DRIVE:    state_d = ST_REQBUS;
            ST_REQBUS:   state_d = ST_RELEASE;
            ST_RELEASE:  state_d = is_read_q ? ST_WAIT_ACK : ST_DONE;
            ST_WAIT_ACK: if (!busack_n) state_d = ST_TRISTATE;
            ST_TRISTATE: state_d = ST_DONE;
            ST_DONE:     if (ioreq_n) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Output decode from the current state.
    always_comb begin
        cap_load   = (state_q == ST_IDLE) && start;
        rf_we      = (state_q == ST_CAPTURE) && !is_read_q;
        drv_en     = (state_q == ST_DRIVE) || (state_q == ST_REQBUS) ||
                     (state_q == ST_WAIT_ACK) ||
                     ((state_q == ST_RELEASE) && is_read_q);
        busrq_n    = !((state_q == ST_REQBUS) || (state_q == ST_WAIT_ACK) ||
                       (state_q == ST_TRISTATE) ||
                       ((state_q == ST_RELEASE) && is_read_q));
        wait_clr_n = (state_q != ST_RELEASE);
    end

    // R1: controls are idle the cycle after reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (busrq_n && wait_clr_n && !drv_en));

    // R4: bus request only asserts while drivers are already on.
    p_busrq_after_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busrq_n) |-> drv_en);

    // R4: a read releases WAIT only under an active bus request.
    p_clear_under_busrq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_clr_n && is_read_q) |-> !busrq_n);

    // R3: a write service never requests the bus.
    p_write_no_busrq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !is_read_q) |-> busrq_n);

    // R5: hold drivers and request until acknowledge.
    p_hold_until_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_ACK && busack_n) |=> (drv_en && !busrq_n));

    // R6: request drops only after the drivers were already off.
    p_off_before_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busrq_n) |-> (!drv_en && $past(!drv_en)));

    // R7: no second service while the same request is held.
    p_single_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !ioreq_n) |=> wait_clr_n);

    // R8: clear pulse lasts one cycle.
    p_clear_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_clr_n |=> wait_clr_n);

endmodule

// File: rtl/io_handback_seq.sv
// Module: io_handback_seq (top)
// Serves CPU I/O cycles held by wait states from a register file and hands the
// data bus back through a bus-request handshake after reads.
// Assumes: all inputs synchronous to clk; the CPU clock runs freely elsewhere.
module io_handback_seq #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ioreq_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [IDX_W-1:0] port_sel,
    input  logic [DW-1:0]    data_in,
    input  logic             busack_n,
    output logic [DW-1:0]    data_out,
    output logic             data_oe,
    output logic             busrq_n,
    output logic             wait_clr_n
);

    logic             cap_load;
    logic             rf_we;
    logic             drv_en;
    logic             is_read_q;
    logic [IDX_W-1:0] idx_q;
    logic [DW-1:0]    rdata;

    io_handback_capture #(.IDX_W(IDX_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cap_load),
        .sel_in    (port_sel),
        .rd_n      (rd_n),
        .idx_q     (idx_q),
        .is_read_q (is_read_q)
    );

    io_handback_regfile #(.DEPTH(DEPTH), .DW(DW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .widx  (idx_q),
        .wdata (data_in),
        .ridx  (idx_q),
        .rdata (rdata)
    );

    io_handback_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ioreq_n    (ioreq_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .busack_n   (busack_n),
        .is_read_q  (is_read_q),
        .cap_load   (cap_load),
        .rf_we      (rf_we),
        .drv_en     (drv_en),
        .busrq_n    (busrq_n),
        .wait_clr_n (wait_clr_n)
    );

    // Present data only while the drivers are enabled.
    always_comb begin
        data_oe  = drv_en;
        data_out = drv_en ? rdata : '0;
    end

endmodule

// File: tb/sim_io_handback_seq.sv
module sim_io_handback_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ioreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, busack_n = 1'b1;
    logic [1:0] port_sel = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe, busrq_n, wait_clr_n;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    io_handback_seq u0 (
        .clk(clk), .rst_n(rst_n), .ioreq_n(ioreq_n), .rd_n(rd_n), .wr_n(wr_n),
        .port_sel(port_sel), .data_in(data_in), .busack_n(busack_n),
        .data_out(data_out), .data_oe(data_oe), .busrq_n(busrq_n),
        .wait_clr_n(wait_clr_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Outputs: oe, busrq_n, wait_clr_n as one 3-bit code.
    function automatic int ctl();
        return {29'd0, data_oe, busrq_n, wait_clr_n};
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        chk("R1 controls in reset", ctl(), 3'b011);
        rst_n = 1'b1;
        step();
        chk("R1 controls after reset", ctl(), 3'b011);
        chk("R1 data_out after reset", data_out, 0);
    endtask

    task automatic t_no_strobe();
        ioreq_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R2 no strobe no service", ctl(), 3'b011);
        end
        ioreq_n = 1'b1;
        step();
    endtask

    task automatic t_write(input logic [1:0] sel, input logic [7:0] val);
        ioreq_n = 1'b0; wr_n = 1'b0; port_sel = sel; data_in = val;
        step();
        chk("R3 write capture quiet", ctl(), 3'b011);
        step();
        chk("R3 write clear pulse no busrq", ctl(), 3'b010);
        step();
        chk("R8 write clear one cycle", ctl(), 3'b011);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R7 held request no re-service", ctl(), 3'b011);
        end
        ioreq_n = 1'b1; wr_n = 1'b1; data_in = 8'h00;
        step();
    endtask

    task automatic t_read(input logic [1:0] sel, input logic [7:0] exp, input int ack_dly);
        ioreq_n = 1'b0; rd_n = 1'b0; port_sel = sel;
        step();
        chk("R4 read capture quiet", ctl(), 3'b011);
        step();
        chk("R4 drive before busrq", ctl(), 3'b111);
        chk("R4 read data", data_out, exp);
        step();
        chk("R4 busrq with drive", ctl(), 3'b101);
        step();
        chk("R4 clear under busrq", ctl(), 3'b100);
        for (int i = 0; i < ack_dly + 1; i++) begin
            step();
            chk("R5 hold until ack", ctl(), 3'b101);
            chk("R5 data held", data_out, exp);
        end
        busack_n = 1'b0;
        step();
        chk("R6 drivers off busrq held", ctl(), 3'b001);
        step();
        chk("R6 busrq released", ctl(), 3'b011);
        busack_n = 1'b1;
        step();
        chk("R7 held read no re-service", ctl(), 3'b011);
        ioreq_n = 1'b1; rd_n = 1'b1;
        step();
        chk("R7 idle after request ends", ctl(), 3'b011);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step();
        t_reset();
        t_no_strobe();
        t_read(2'd2, 8'h00, 0);          // R1 entries reset to zero
        t_write(2'd1, 8'hA5);
        t_write(2'd3, 8'h3C);
        t_read(2'd1, 8'hA5, 0);
        t_read(2'd3, 8'h3C, 7);          // long acknowledge delay
        t_read(2'd0, 8'h00, 2);          // R9 untouched neighbour
        t_read(2'd2, 8'h00, 1);          // R9 untouched neighbour
        t_write(2'd1, 8'h5A);
        t_read(2'd1, 8'h5A, 0);
        t_read(2'd3, 8'h3C, 0);          // R9 other entry unchanged
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule